// File: doc/BRIEF.md
# Dual PDM microphone clock generator and bit splitter

The block drives the clock pin for one or two pulse-density-modulated microphones that share a single data wire. The clock comes from an integer division of the system clock, so its rate stays tied to the audio sample rate. The two microphones take turns on the wire according to the clock level. The first microphone drives while the clock is high and the second drives while it is low. Each one releases the wire while the other is talking.

The shared wire first passes through a two-stage synchronizer. The block then takes one sample near the centre of every clock phase and ignores the rest of the phase, when the wire may be floating or changing. High-phase samples leave on channel 1 and low-phase samples on channel 2, each with a one-cycle valid strobe. A decimation filter would normally follow. The divider value must be picked so that the clock falls between 1 and 3 MHz and is a whole multiple of the sample rate. When capture is switched off the clock pin is held low.

Top module: `pdm_dual_capture`

## Requirements
- R1: With divider setting N, the microphone clock stays high for H system clocks and then low for H system clocks, where H = N/2. A value of N below 4 is treated as 4, and an odd N is rounded down to the next even value (7 behaves as 6).
- R2: At the first rising system-clock edge that samples `enable` high, `mic_clk` goes high, and every run starts with a high phase.
- R3: Within a phase, cycles are numbered from 0, starting at the cycle in which `mic_clk` takes its new level. The captured bit is the `mic_data_in` value present during cycle floor(H/2). Values on the wire in every other cycle of the phase have no effect on the outputs.
- R4: A bit captured in a high phase appears on `ch1_bit` together with a one-cycle `ch1_valid` pulse. A bit captured in a low phase appears on `ch2_bit` with a one-cycle `ch2_valid` pulse. The two strobes are never high in the same cycle.
- R5: The valid strobe and its bit appear exactly three system clocks after the sampled cycle: two synchronizer stages plus one output register.
- R6: A new divider value is taken only at the next rising edge of `mic_clk`. The phases that are already under way keep their old length.
- R7: During reset, and from the cycle after `enable` is sampled low, `mic_clk` is low and neither strobe is issued. A later enable starts a fresh high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock and the capture |
| div_sel | input | DIV_W | Microphone clock period in system clocks |
| mic_data_in | input | 1 | Shared microphone data wire |
| mic_clk | output | 1 | Clock to the microphones |
| ch1_bit | output | 1 | Latest high-phase bit |
| ch1_valid | output | 1 | One-cycle strobe for ch1_bit |
| ch2_bit | output | 1 | Latest low-phase bit |
| ch2_valid | output | 1 | One-cycle strobe for ch2_bit |

## Verification
A microphone model drives the true bit only in the mid-phase cycle and its inverse everywhere else. A design that sampled one cycle off, on an edge, or without accounting for the synchronizer delay would therefore deliver inverted bits, or deliver them at the wrong latency. The divider settings 4, 6, 10, 7 and 2 cover the shortest phase, odd half-periods and the rounding rule, so an off-by-one in the phase counter shows up as a wrong phase length. A divider change made in the middle of a high phase catches a design that shortens the phase in progress. Toggling enable checks that the clock parks low, that no stale strobe leaks out, and that the restart begins high.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  // Half period in system clocks after clamping and rounding the setting
  function automatic int unsigned half_of(int unsigned n);
    int unsigned m;
    m = (n < 4) ? 4 : n;
    return m / 2;
  endfunction

  // Position inside a phase at which the wire is sampled
  function automatic int unsigned mid_of(int unsigned h);
    return h / 2;
  endfunction
endpackage

// File: rtl/pdm_sync.sv
module pdm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_sel,
  output logic             mic_clk,
  output logic             running,
  output logic             phase_end,
  output logic             mid_evt,
  output logic [DIV_W-1:0] half_cur
);
  import pdm_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_next;
  logic [DIV_W-1:0] mid_pos;

  assign half_next = DIV_W'(half_of(32'(div_sel)));
  assign mid_pos   = DIV_W'(mid_of(32'(half_cur)));
  assign phase_end = running && (cnt == half_cur - DIV_W'(1));
  assign mid_evt   = running && (cnt == mid_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mic_clk  <= 1'b0;
      running  <= 1'b0;
      cnt      <= '0;
      half_cur <= DIV_W'(2);
    end else if (!enable) begin
      mic_clk <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      running  <= 1'b1;
      mic_clk  <= 1'b1;
      cnt      <= '0;
      half_cur <= half_next;
    end else if (phase_end) begin
      cnt     <= '0;
      mic_clk <= ~mic_clk;
      if (!mic_clk) half_cur <= half_next;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pdm_splitter.sv
module pdm_splitter #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic mark,
  input  logic level,
  input  logic data_sync,
  output logic ch1_bit,
  output logic ch1_valid,
  output logic ch2_bit,
  output logic ch2_valid
);
  logic [STAGES-1:0] mark_d;
  logic [STAGES-1:0] level_d;
  logic              take;
  logic              take_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_d  <= '0;
      level_d <= '0;
    end else if (!enable) begin
      mark_d  <= '0;
      level_d <= '0;
    end else begin
      mark_d  <= {mark_d[STAGES-2:0], mark};
      level_d <= {level_d[STAGES-2:0], level};
    end
  end

  assign take    = mark_d[STAGES-1];
  assign take_hi = level_d[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch1_bit   <= 1'b0;
      ch2_bit   <= 1'b0;
      ch1_valid <= 1'b0;
      ch2_valid <= 1'b0;
    end else begin
      ch1_valid <= enable && take && take_hi;
      ch2_valid <= enable && take && !take_hi;
      if (enable && take && take_hi)  ch1_bit <= data_sync;
      if (enable && take && !take_hi) ch2_bit <= data_sync;
    end
  end
endmodule

// File: rtl/pdm_dual_capture.sv
module pdm_dual_capture #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             mic_data_in,
  output logic             mic_clk,
  output logic             ch1_bit,
  output logic             ch1_valid,
  output logic             ch2_bit,
  output logic             ch2_valid
);
  logic             running;
  logic             phase_end;
  logic             mid_evt;
  logic [DIV_W-1:0] half_cur;
  logic             data_sync;

  pdm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
    .mic_clk(mic_clk), .running(running), .phase_end(phase_end),
    .mid_evt(mid_evt), .half_cur(half_cur)
  );

  pdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mic_data_in), .q(data_sync)
  );

  // The sample marker travels through as many registers as the data
  pdm_splitter #(.STAGES(SYNC_STAGES)) u_split (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mark(mid_evt),
    .level(mic_clk), .data_sync(data_sync),
    .ch1_bit(ch1_bit), .ch1_valid(ch1_valid),
    .ch2_bit(ch2_bit), .ch2_valid(ch2_valid)
  );
endmodule

// File: rtl/pdm_dual_checker.sv
module pdm_dual_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             mic_clk,
  input logic             ch1_valid,
  input logic             ch2_valid,
  input logic             running,
  input logic             phase_end,
  input logic [DIV_W-1:0] half_cur
);
  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !mic_clk); // R7

  AST_NO_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ch1_valid && !ch2_valid)); // R7

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch1_valid && ch2_valid)); // R4

  AST_CH1_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_valid |=> !ch1_valid); // R4

  AST_CH2_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_valid |=> !ch2_valid); // R4

  AST_PHASE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running && !$stable(mic_clk)) |-> $past(phase_end)); // R1

  AST_DIV_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running && !$stable(half_cur)) |-> $rose(mic_clk)); // R6
endmodule

bind pdm_dual_capture pdm_dual_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mic_clk(mic_clk),
  .ch1_valid(ch1_valid), .ch2_valid(ch2_valid), .running(running),
  .phase_end(phase_end), .half_cur(half_cur)
);

// File: tb/sim_pdm_dual_capture.sv
`timescale 1ns/1ps
module sim_pdm_dual_capture;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [DIV_W-1:0] div_sel = 8'd4;
  logic             mic_data_in = 1'b0;
  logic             mic_clk, ch1_bit, ch1_valid, ch2_bit, ch2_valid;

  int n_chk = 0;
  int n_bad = 0;

  pdm_dual_capture #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
    .mic_data_in(mic_data_in), .mic_clk(mic_clk),
    .ch1_bit(ch1_bit), .ch1_valid(ch1_valid),
    .ch2_bit(ch2_bit), .ch2_valid(ch2_valid)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int half_exp(input int n);
    int m;
    m = (n < 4) ? 4 : n - (n % 2);
    return m / 2;
  endfunction

  // Microphone model and output scoreboard
  int    cyc = 0;
  int    pos = 0;
  int    phalf = 2;
  bit    prev_clk = 0;
  bit    seen_rise = 0;
  bit    cur_bit = 0;
  bit    stuck_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  int    q1_bit[$], q1_t[$], q2_bit[$], q2_t[$];
  int    pops1 = 0, pops2 = 0;
  string len_tag = "R1";

  always @(negedge clk) begin
    cyc++;
    if (!rst_n || !enable) begin
      if (rst_n) check(!mic_clk && !ch1_valid && !ch2_valid, "R7 idle outputs",
                       {mic_clk, ch1_valid, ch2_valid}, 0);
      q1_bit.delete(); q1_t.delete(); q2_bit.delete(); q2_t.delete();
      prev_clk = 0; seen_rise = 0; pos = 0; mic_data_in = 0;
    end else begin
      if (ch1_valid) begin
        if (q1_bit.size() == 0) check(0, "R4 unexpected ch1_valid", 1, 0);
        else begin
          check(ch1_bit == q1_bit[0], "R3 ch1 bit", ch1_bit, q1_bit[0]);
          check(cyc == q1_t[0] + 3, "R5 ch1 latency", cyc - q1_t[0], 3);
          void'(q1_bit.pop_front()); void'(q1_t.pop_front());
          pops1++;
        end
      end
      if (ch2_valid) begin
        if (q2_bit.size() == 0) check(0, "R4 unexpected ch2_valid", 1, 0);
        else begin
          check(ch2_bit == q2_bit[0], "R3 ch2 bit", ch2_bit, q2_bit[0]);
          check(cyc == q2_t[0] + 3, "R5 ch2 latency", cyc - q2_t[0], 3);
          void'(q2_bit.pop_front()); void'(q2_t.pop_front());
          pops2++;
        end
      end
      if (q1_bit.size() > 0 && cyc > q1_t[0] + 3) begin
        check(0, "R4 missing ch1_valid", 0, 1); void'(q1_bit.pop_front()); void'(q1_t.pop_front());
      end
      if (q2_bit.size() > 0 && cyc > q2_t[0] + 3) begin
        check(0, "R4 missing ch2_valid", 0, 1); void'(q2_bit.pop_front()); void'(q2_t.pop_front());
      end
      if (mic_clk != prev_clk) begin
        if (prev_clk) check(pos + 1 == phalf, {len_tag, " high length"}, pos + 1, phalf);
        else if (seen_rise) check(pos + 1 == phalf, {len_tag, " low length"}, pos + 1, phalf);
        if (mic_clk) begin
          phalf = half_exp(int'(div_sel));
          seen_rise = 1;
        end
        pos = 0;
      end else begin
        pos++;
      end
      if (pos > 200 && !stuck_seen) begin
        stuck_seen = 1;
        check(0, "R1 clock stuck", pos, phalf);
      end
      prev_clk = mic_clk;
      if (pos == 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cur_bit = lfsr[0];
      end
      if (pos == phalf / 2) begin
        mic_data_in = cur_bit;
        if (mic_clk) begin q1_bit.push_back(int'(cur_bit)); q1_t.push_back(cyc); end
        else         begin q2_bit.push_back(int'(cur_bit)); q2_t.push_back(cyc); end
      end else begin
        mic_data_in = ~cur_bit;
      end
    end
  end

  task automatic drive(input bit en, input int d);
    @(negedge clk); #1;
    enable = en;
    div_sel = DIV_W'(d);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!mic_clk && !ch1_valid && !ch2_valid, "R7 reset state",
          {mic_clk, ch1_valid, ch2_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!mic_clk, "R7 clock low after reset", mic_clk, 0);
  endtask

  // Start, run a number of periods, check both channels delivered
  task automatic t_run(input int d, input int periods);
    int p1, p2;
    drive(1'b1, d);
    @(negedge clk);
    check(mic_clk, "R2 first phase high", mic_clk, 1);
    p1 = pops1; p2 = pops2;
    repeat (periods * 2 * half_exp(d)) @(negedge clk);
    check(pops1 - p1 >= periods - 2, "R4 ch1 count", pops1 - p1, periods);
    check(pops2 - p2 >= periods - 2, "R4 ch2 count", pops2 - p2, periods);
    drive(1'b0, d);
    repeat (4) @(negedge clk);
    check(!mic_clk && !ch1_valid && !ch2_valid, "R7 after disable",
          {mic_clk, ch1_valid, ch2_valid}, 0);
  endtask

  // R6: change the divider in the middle of a high phase
  task automatic t_change();
    drive(1'b1, 8);
    repeat (40) @(negedge clk);
    while (!(mic_clk && pos == 1)) @(negedge clk);
    len_tag = "R6";
    #1 div_sel = 8'd12;
    repeat (60) @(negedge clk);
    check(phalf == 6, "R6 new half in use", phalf, 6);
    len_tag = "R1";
    drive(1'b0, 12);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_run(4, 20);
    t_run(6, 20);
    t_run(10, 15);
    t_run(7, 15);
    t_run(2, 15);
    t_change();
    t_run(16, 6);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule